// File: doc/BRIEF.md
# Four-Way Set-Associative Data Cache

This block is a data cache placed between a processor's 32-bit load/store port and a plain word-at-a-time memory port. Each set holds four lines, and each line holds four 32-bit words. The default build has 128 sets, for 8 Kbytes of data. An access address is split into a tag, a set index and a word offset. The four stored tags of the indexed set are compared in parallel, and a read hit returns the addressed word in the same cycle as the request.

A read miss picks a victim line and writes the victim back if it holds modified data. It then fetches the new line one word at a time and finishes as a hit. Each write carries its own mode bit. A copyback write updates only the cache and marks the line modified; on a miss it first allocates the line as a read miss would. A write-through write always sends exactly one word to memory. It updates the cached copy only if the line is already present, and it never marks a line modified. On a write-through miss no line is allocated.

The processor holds `cpu_req` and its operands steady until it sees `cpu_ready`, which is high for one cycle. The memory side holds `mem_req` and its operands until `mem_ack`, and each acknowledge carries one word.

Top module: `dc_cache`

## Requirements
- R1: While `rst_n` is low on a clock edge, every line's valid and modified bits and every set's replacement pointer are cleared. In the cycle after reset, `mem_req` and `cpu_ready` are low, and the first access to any address misses.
- R2: The address is decoded as follows: bits [3:2] select the word, bits [3+log2(SETS):4] select the set (bits [10:4] by default), and all higher bits form the stored tag. Two addresses that differ only in their tag bits map to different lines of the same set.
- R3: A read hit raises `cpu_ready` combinationally in the first cycle of the request. It returns the addressed word on `cpu_rdata` and makes no memory access. `cpu_ready` is never high without `cpu_req`.
- R4: A read miss reads words 0, 1, 2, 3 of the requested line from memory in that order, at word addresses line_base + 4*k. It then returns the requested word.
- R5: On allocation, the victim is the lowest-numbered invalid way of the set. If all four ways are valid, the victim is the way named by that set's round-robin pointer, and the pointer then advances by one modulo 4. The pointer changes only when it is used.
- R6: If the victim is valid and modified, its four words are written to memory in order 0 to 3, at the victim's own tag and set address, before the fill starts.
- R7: A copyback write hit (`cpu_we`=1, `cpu_wt`=0) updates the cached word in the cycle of the request, makes no memory access, and marks the line modified.
- R8: A copyback write miss allocates and fills the line as in R4 to R6, then writes the word into it and marks the line modified.
- R9: A write-through write (`cpu_we`=1, `cpu_wt`=1) performs exactly one memory write of `cpu_addr` and `cpu_wdata`, and `cpu_ready` rises with that write's `mem_ack`. On a hit the cached word is also updated, and the line's modified state is unchanged.
- R10: A write-through write miss allocates no line, so a later read of that address misses.
- R11: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` are held steady until `mem_ack`, and each acknowledge moves one word. `cpu_wt` has no effect on reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wt | input | 1 | Write mode: 1 = write-through, 0 = copyback |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` on reads |
| cpu_ready | output | 1 | One-cycle completion strobe |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Completes the current memory word |

## Verification
The bench builds the cache with SETS=4 and leaves the address width, data width, way count and line length at their defaults. The set index is then bits [5:4] and the tag is bits [31:6]. With only four sets, a fifth tag evicts from a set after a handful of accesses. This brings pointer wrap-around, dirty writebacks, clean evictions and the write-through-then-evict case into both the directed and the random phases. The memory responder waits 0 to 2 cycles at random before each acknowledge, which exercises the hold rule of R11.

// File: rtl/dc_pkg.sv
// Shared types for the data cache.
// Assumes: imported by the controller; no other state is shared.
package dc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // lookup and completion of hits
        ST_WBACK = 2'd1,   // write a modified victim back to memory
        ST_FILL  = 2'd2,   // fetch a line word by word
        ST_WTHRU = 2'd3    // forward one write-through word
    } dc_state_t;
endpackage

// File: rtl/dc_way_tags.sv
// One way's tag, valid and modified storage with its tag comparator.
// Assumes: allocation and dirty marking are never requested in the same cycle.
module dc_way_tags #(
    parameter int SETS  = 128,
    parameter int TAG_W = 21,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] cmp_tag,
    input  logic             alloc_en,
    input  logic             mark_dirty,
    output logic             hit,
    output logic             line_valid,
    output logic             line_dirty,
    output logic [TAG_W-1:0] line_tag
);
    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  dirty_q;
    logic [TAG_W-1:0] tag_q [SETS];

    // Status bits: cleared by reset, set on allocation or copyback write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (alloc_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (mark_dirty) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    // Tag storage: written only when a line is allocated.
    always_ff @(posedge clk) begin
        if (alloc_en) tag_q[idx] <= cmp_tag;
    end

    // Lookup: the line must be valid and its tag must match.
    always_comb begin
        line_valid = valid_q[idx];
        line_dirty = dirty_q[idx];
        line_tag   = tag_q[idx];
        hit        = valid_q[idx] && (tag_q[idx] == cmp_tag);
    end
endmodule

// File: rtl/dc_data_store.sv
// Line data storage: one write port and two asynchronous read ports.
// Assumes: addresses are the concatenation {way, set, word}.
module dc_data_store #(
    parameter int AW     = 11,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << AW
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [AW-1:0]     rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    // Word write from the processor or from a memory fill.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    // Read ports: port A serves processor hits, port B serves writebacks.
    assign rd_data_a = mem_q[rd_addr_a];
    assign rd_data_b = mem_q[rd_addr_b];
endmodule

// File: rtl/dc_ctrl.sv
// Cache sequencer: hit handling, victim choice, writeback, fill and write-through.
// Assumes: processor operands are stable while cpu_req is high; WAYS and WORDS are powers of two.
module dc_ctrl
    import dc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SETS   = 128,
    parameter int WAYS   = 4,
    parameter int WORDS  = 4,
    parameter int BYTE_W = 2,
    localparam int IDX_W    = $clog2(SETS),
    localparam int OFF_W    = $clog2(WORDS),
    localparam int WAY_W    = $clog2(WAYS),
    localparam int LINE_LSB = BYTE_W + OFF_W,
    localparam int TAG_W    = ADDR_W - IDX_W - LINE_LSB
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cpu_req,
    input  logic                       cpu_we,
    input  logic                       cpu_wt,
    input  logic [ADDR_W-1:0]          cpu_addr,
    input  logic                       mem_ack,
    input  logic [WAYS-1:0]            hit_vec,
    input  logic [WAYS-1:0]            valid_vec,
    input  logic [WAYS-1:0]            dirty_vec,
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    output logic                       cpu_ready,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic                       wb_phase,
    output logic [WAYS-1:0]            alloc_vec,
    output logic [WAYS-1:0]            mark_vec,
    output logic                       dwr_en,
    output logic [WAY_W-1:0]           dwr_way,
    output logic [OFF_W-1:0]           dwr_off,
    output logic                       dwr_from_mem,
    output logic [WAY_W-1:0]           hit_way,
    output logic [WAY_W-1:0]           vic_way,
    output logic [OFF_W-1:0]           word_cnt
);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORDS - 1);
    localparam logic [OFF_W-1:0] ONE_OFF  = OFF_W'(1);
    localparam logic [WAY_W-1:0] ONE_WAY  = WAY_W'(1);

    dc_state_t        state_q;
    logic [OFF_W-1:0] cnt_q;
    logic [WAY_W-1:0] vic_q, wt_way_q, first_inv, victim;
    logic [TAG_W-1:0] vic_tag_q;
    logic             wt_hit_q, hit_any, all_valid;
    logic [WAY_W-1:0] rr_q [SETS];

    wire [IDX_W-1:0] idx = cpu_addr[LINE_LSB +: IDX_W];
    wire [OFF_W-1:0] off = cpu_addr[BYTE_W +: OFF_W];
    wire [TAG_W-1:0] tag = cpu_addr[ADDR_W-1 -: TAG_W];

    // Hit encoding and victim choice: lowest invalid way, else the round-robin pointer.
    always_comb begin
        hit_way   = '0;
        first_inv = '0;
        for (int w = 0; w < WAYS; w++)
            if (hit_vec[w]) hit_way = WAY_W'(w);
        for (int w = WAYS - 1; w >= 0; w--)
            if (!valid_vec[w]) first_inv = WAY_W'(w);
        hit_any   = |hit_vec;
        all_valid = &valid_vec;
        victim    = all_valid ? rr_q[idx] : first_inv;
    end

    // Per-state outputs toward memory, the arrays and the processor.
    always_comb begin
        cpu_ready    = 1'b0;
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        mem_addr     = cpu_addr;
        wb_phase     = 1'b0;
        alloc_vec    = '0;
        mark_vec     = '0;
        dwr_en       = 1'b0;
        dwr_way      = hit_way;
        dwr_off      = off;
        dwr_from_mem = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (cpu_req && !(cpu_we && cpu_wt) && hit_any) begin
                    cpu_ready = 1'b1;
                    if (cpu_we) begin
                        dwr_en            = 1'b1;
                        mark_vec[hit_way] = 1'b1;
                    end
                end
            end
            ST_WBACK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                wb_phase = 1'b1;
                mem_addr = {vic_tag_q, idx, cnt_q, {BYTE_W{1'b0}}};
            end
            ST_FILL: begin
                mem_req      = 1'b1;
                mem_addr     = {tag, idx, cnt_q, {BYTE_W{1'b0}}};
                dwr_way      = vic_q;
                dwr_off      = cnt_q;
                dwr_from_mem = 1'b1;
                dwr_en       = mem_ack;
                if (mem_ack && cnt_q == LAST_OFF) alloc_vec[vic_q] = 1'b1;
            end
            ST_WTHRU: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                cpu_ready = mem_ack;
                dwr_way   = wt_way_q;
                dwr_en    = mem_ack && wt_hit_q;
            end
            default: ;
        endcase
    end

    // Sequencer state, word counter and latched victim or write-through hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            vic_q     <= '0;
            vic_tag_q <= '0;
            wt_hit_q  <= 1'b0;
            wt_way_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cpu_req && cpu_we && cpu_wt) begin
                        state_q  <= ST_WTHRU;
                        wt_hit_q <= hit_any;
                        wt_way_q <= hit_way;
                    end else if (cpu_req && !hit_any) begin
                        vic_q     <= victim;
                        vic_tag_q <= way_tag[victim];
                        cnt_q     <= '0;
                        state_q   <= (valid_vec[victim] && dirty_vec[victim]) ? ST_WBACK : ST_FILL;
                    end
                end
                ST_WBACK: if (mem_ack) begin
                    cnt_q <= cnt_q + ONE_OFF;
                    if (cnt_q == LAST_OFF) state_q <= ST_FILL;
                end
                ST_FILL: if (mem_ack) begin
                    cnt_q <= cnt_q + ONE_OFF;
                    if (cnt_q == LAST_OFF) state_q <= ST_IDLE;
                end
                ST_WTHRU: if (mem_ack) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Round-robin pointers: advance only when a full set supplies the victim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
        end else if (state_q == ST_IDLE && cpu_req && !(cpu_we && cpu_wt)
                     && !hit_any && all_valid) begin
            rr_q[idx] <= rr_q[idx] + ONE_WAY;
        end
    end

    assign vic_way  = vic_q;
    assign word_cnt = cnt_q;
endmodule

// File: rtl/dc_cache.sv
// Top level of the set-associative data cache: per-way tag blocks, data store, sequencer.
// Assumes: word-aligned accesses; SETS, WAYS and WORDS are powers of two.
module dc_cache #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SETS   = 128,
    parameter int WAYS   = 4,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_wt,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int BYTE_W   = $clog2(DATA_W / 8);
    localparam int IDX_W    = $clog2(SETS);
    localparam int OFF_W    = $clog2(WORDS);
    localparam int WAY_W    = $clog2(WAYS);
    localparam int LINE_LSB = BYTE_W + OFF_W;
    localparam int TAG_W    = ADDR_W - IDX_W - LINE_LSB;
    localparam int AW       = WAY_W + IDX_W + OFF_W;

    wire [IDX_W-1:0] idx = cpu_addr[LINE_LSB +: IDX_W];
    wire [OFF_W-1:0] off = cpu_addr[BYTE_W +: OFF_W];
    wire [TAG_W-1:0] tag = cpu_addr[ADDR_W-1 -: TAG_W];

    logic [WAYS-1:0]            hit_vec, valid_vec, dirty_vec, alloc_vec, mark_vec;
    logic [WAYS-1:0][TAG_W-1:0] way_tag;
    logic                       wb_phase, dwr_en, dwr_from_mem;
    logic [WAY_W-1:0]           dwr_way, hit_way, vic_way;
    logic [OFF_W-1:0]           dwr_off, word_cnt;
    logic [DATA_W-1:0]          wb_data;

    // One tag, status and comparator block per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        dc_way_tags #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
            .clk        (clk),
            .rst_n      (rst_n),
            .idx        (idx),
            .cmp_tag    (tag),
            .alloc_en   (alloc_vec[w]),
            .mark_dirty (mark_vec[w]),
            .hit        (hit_vec[w]),
            .line_valid (valid_vec[w]),
            .line_dirty (dirty_vec[w]),
            .line_tag   (way_tag[w])
        );
    end

    dc_data_store #(.AW(AW), .DATA_W(DATA_W)) u_data (
        .clk       (clk),
        .wr_en     (dwr_en),
        .wr_addr   ({dwr_way, idx, dwr_off}),
        .wr_data   (dwr_from_mem ? mem_rdata : cpu_wdata),
        .rd_addr_a ({hit_way, idx, off}),
        .rd_data_a (cpu_rdata),
        .rd_addr_b ({vic_way, idx, word_cnt}),
        .rd_data_b (wb_data)
    );

    dc_ctrl #(
        .ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .WORDS(WORDS), .BYTE_W(BYTE_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .cpu_wt       (cpu_wt),
        .cpu_addr     (cpu_addr),
        .mem_ack      (mem_ack),
        .hit_vec      (hit_vec),
        .valid_vec    (valid_vec),
        .dirty_vec    (dirty_vec),
        .way_tag      (way_tag),
        .cpu_ready    (cpu_ready),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .wb_phase     (wb_phase),
        .alloc_vec    (alloc_vec),
        .mark_vec     (mark_vec),
        .dwr_en       (dwr_en),
        .dwr_way      (dwr_way),
        .dwr_off      (dwr_off),
        .dwr_from_mem (dwr_from_mem),
        .hit_way      (hit_way),
        .vic_way      (vic_way),
        .word_cnt     (word_cnt)
    );

    // Memory write data: a victim word during writeback, otherwise the processor word.
    assign mem_wdata = wb_phase ? wb_data : cpu_wdata;
endmodule

// File: rtl/dc_cache_chk.sv
// Protocol checker for the data cache, attached to every instance by bind.
// Assumes: the processor holds its operands while cpu_req is high.
module dc_cache_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SETS   = 128,
    parameter int WAYS   = 4,
    parameter int WORDS  = 4,
    localparam int LINE_LSB = $clog2(DATA_W / 8) + $clog2(WORDS),
    localparam int IDX_W    = $clog2(SETS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic              cpu_wt,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic [WAYS-1:0]   hit_vec
);
    // R1: no memory request and no completion in the first cycle out of reset.
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!mem_req && !cpu_ready));

    // R2: at most one way of the indexed set can match.
    p_hit_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R3: completion only while a request is presented.
    p_ready_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_req);

    // R4: fill reads target the requested line.
    p_fill_same_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (mem_addr[ADDR_W-1:LINE_LSB] == cpu_addr[ADDR_W-1:LINE_LSB]));

    // R6: writebacks use the same set but another tag.
    p_wb_other_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !(cpu_we && cpu_wt)) |->
        ((mem_addr[LINE_LSB +: IDX_W] == cpu_addr[LINE_LSB +: IDX_W])
         && (mem_addr[ADDR_W-1:LINE_LSB] != cpu_addr[ADDR_W-1:LINE_LSB])));

    // R7: a copyback write completes with no memory access in that cycle.
    p_cb_write_local_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_we && !cpu_wt) |-> !mem_req);

    // R9: a write-through completion coincides with its memory write.
    p_wt_done_with_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_we && cpu_wt) |->
        (mem_req && mem_we && mem_ack && mem_addr == cpu_addr && mem_wdata == cpu_wdata));

    // R11: memory request and operands hold until acknowledged.
    p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=>
        (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));
endmodule

bind dc_cache dc_cache_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .WAYS(WAYS), .WORDS(WORDS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_wt    (cpu_wt),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .hit_vec   (hit_vec)
);

// File: tb/dc_cache_tb_top.sv
// Bench for the data cache: a behavioural reference model predicts every memory
// word and every read result; a responder checks memory traffic on each clock.
`timescale 1ns/100ps
module dc_cache_tb_top;
    localparam int SETS  = 4;
    localparam int WAYS  = 4;
    localparam int WORDS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_wt = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    always #2.5 clk = ~clk;

    dc_cache #(.SETS(SETS)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_wt(cpu_wt),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Main memory: sparse store with an address-derived initial pattern.
    logic [31:0] mem_arr [int unsigned];
    function automatic logic [31:0] mem_peek(logic [31:0] a);
        if (mem_arr.exists(a)) return mem_arr[a];
        return a ^ 32'h5A5A_A5A5;
    endfunction

    // Reference model of cache contents.
    bit          m_valid [SETS][WAYS];
    bit          m_dirty [SETS][WAYS];
    logic [31:0] m_tag   [SETS][WAYS];
    logic [31:0] m_line  [SETS][WAYS][WORDS];
    int          m_rr    [SETS];

    typedef struct { bit we; logic [31:0] addr; logic [31:0] data; } op_t;
    op_t exp_q[$];

    function automatic void model_reset();
        for (int s = 0; s < SETS; s++) begin
            m_rr[s] = 0;
            for (int w = 0; w < WAYS; w++) begin
                m_valid[s][w] = 0;
                m_dirty[s][w] = 0;
            end
        end
    endfunction

    function automatic void push_op(bit we, logic [31:0] a, logic [31:0] d);
        op_t o;
        o.we = we; o.addr = a; o.data = d;
        exp_q.push_back(o);
    endfunction

    // Predict one access: queue the expected memory words, return the expected read
    // data and whether it is a hit.
    function automatic logic [31:0] model_access(bit we, bit wt, logic [31:0] a,
                                                 logic [31:0] d, output bit was_hit);
        int s, off, hw, v;
        logic [31:0] t, base;
        s    = int'((a >> 4) % SETS);
        off  = int'((a >> 2) & 3);
        t    = a >> 6;
        base = a & ~32'hF;
        hw   = -1;
        for (int w = 0; w < WAYS; w++)
            if (m_valid[s][w] && m_tag[s][w] == t) hw = w;
        was_hit = (hw >= 0);
        if (we && wt) begin
            push_op(1, a, d);
            if (hw >= 0) m_line[s][hw][off] = d;
            return '0;
        end
        if (hw < 0) begin
            v = -1;
            for (int w = WAYS - 1; w >= 0; w--) if (!m_valid[s][w]) v = w;
            if (v < 0) begin
                v = m_rr[s];
                m_rr[s] = (m_rr[s] + 1) % WAYS;
            end
            if (m_valid[s][v] && m_dirty[s][v])
                for (int k = 0; k < WORDS; k++)
                    push_op(1, (m_tag[s][v] << 6) | (s << 4) | (k << 2), m_line[s][v][k]);
            for (int k = 0; k < WORDS; k++) begin
                push_op(0, base | (k << 2), '0);
                m_line[s][v][k] = mem_peek(base | (k << 2));
            end
            m_valid[s][v] = 1; m_dirty[s][v] = 0; m_tag[s][v] = t;
            hw = v;
        end
        if (we) begin
            m_line[s][hw][off] = d;
            m_dirty[s][hw] = 1;
            return '0;
        end
        return m_line[s][hw][off];
    endfunction

    // Memory responder: random wait, hold check, then one word compared against the model.
    bit          pend = 0;
    int          wait_n = 0;
    logic [31:0] p_addr, p_wdata;
    bit          p_we;
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 0; pend = 0;
        end else if (mem_ack) begin
            mem_ack = 0;
        end else if (mem_req) begin
            if (!pend) begin
                pend = 1; p_addr = mem_addr; p_we = mem_we; p_wdata = mem_wdata;
                wait_n = $urandom_range(0, 2);
            end
            if (wait_n == 0) begin
                pend = 0;
                check(p_addr == mem_addr && p_we == mem_we && p_wdata == mem_wdata,
                      "R11", "memory operands held until ack", mem_addr, p_addr);
                if (exp_q.size() == 0) begin
                    check(0, cur_req, "unexpected memory access", mem_addr, 32'hFFFF_FFFF);
                end else begin
                    op_t o;
                    o = exp_q.pop_front();
                    check(o.we == mem_we, cur_req, "memory direction", {31'd0, mem_we}, {31'd0, o.we});
                    check(o.addr == mem_addr, cur_req, "memory address", mem_addr, o.addr);
                    if (o.we)
                        check(o.data == mem_wdata, cur_req, "memory write data", mem_wdata, o.data);
                end
                if (mem_we) mem_arr[mem_addr] = mem_wdata;
                else        mem_rdata = mem_peek(mem_addr);
                mem_ack = 1;
            end else begin
                wait_n--;
            end
        end
    end

    // One processor access, compared against the model at completion.
    task automatic access(string req, bit we, bit wt, logic [31:0] a, logic [31:0] d);
        logic [31:0] exp_rd;
        bit          hit;
        int          waits;
        cur_req = req;
        exp_rd  = model_access(we, wt, a, d, hit);
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_wt = wt; cpu_addr = a; cpu_wdata = d;
        waits = 0;
        #1;
        while (!cpu_ready && waits < 500) begin
            @(negedge clk); #1; waits++;
        end
        check(cpu_ready, req, "access completes", {31'd0, cpu_ready}, 32'd1);
        if (hit && !(we && wt))
            check(waits == 0, "R3", "hit completes in first cycle", waits, 0);
        if (!we) check(cpu_rdata == exp_rd, req, "read data", cpu_rdata, exp_rd);
        check(exp_q.size() == 0, req, "all expected memory words seen", exp_q.size(), 0);
        exp_q.delete();
        @(posedge clk);
        @(negedge clk);
        cpu_req = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        cpu_req = 0; rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_reset();
        #1;
        check(!mem_req && !cpu_ready, "R1", "outputs quiet after reset",
              {30'd0, mem_req, cpu_ready}, 32'd0);
    endtask

    function automatic logic [31:0] adr(int t, int s, int o);
        return (32'(t) << 6) | (32'(s) << 4) | (32'(o) << 2);
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            check(0, "WDOG", "watchdog expired", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();
        access("R1", 0, 0, adr(1, 0, 2), 0);            // first access misses after reset
        access("R4", 0, 0, adr(1, 1, 3), 0);            // fill order 0..3
        access("R3", 0, 0, adr(1, 0, 3), 0);            // hit, no traffic
        access("R7", 1, 0, adr(1, 0, 1), 32'h1111_1111);
        access("R7", 0, 0, adr(1, 0, 1), 0);
        access("R5", 0, 0, adr(2, 0, 0), 0);            // ways 1..3 taken while invalid
        access("R5", 0, 0, adr(3, 0, 0), 0);
        access("R5", 0, 0, adr(4, 0, 0), 0);
        access("R6", 0, 0, adr(5, 0, 0), 0);            // pointer 0: dirty tag 1 written back
        access("R6", 0, 0, adr(1, 0, 1), 0);            // pointer 1: clean, data from memory
        access("R9", 1, 1, adr(3, 0, 2), 32'h2222_2222); // write-through hit
        access("R9", 0, 0, adr(3, 0, 2), 0);
        access("R9", 0, 0, adr(6, 0, 0), 0);            // pointer 2 evicts tag 3: no writeback
        access("R10", 1, 1, adr(9, 1, 0), 32'h3333_3333);
        access("R10", 0, 0, adr(9, 1, 0), 0);           // must miss
        access("R8", 1, 0, adr(7, 2, 1), 32'h4444_4444);
        access("R8", 0, 0, adr(7, 2, 1), 0);
        access("R2", 0, 0, adr(32'h100001, 3, 0), 0);
        access("R2", 0, 0, adr(1, 3, 0), 0);
        access("R2", 0, 0, adr(32'h100001, 3, 2), 0);
        access("R11", 0, 1, adr(1, 3, 1), 0);           // mode bit ignored on a read hit
        access("R1", 1, 0, adr(1, 3, 0), 32'h5555_5555);
        do_reset();
        access("R1", 0, 0, adr(1, 3, 0), 0);            // dirty data dropped by reset
        for (int i = 0; i < 500; i++) begin
            logic [31:0] a;
            bit          we, wt;
            a  = adr($urandom_range(0, 7), $urandom_range(0, SETS - 1), $urandom_range(0, 3));
            we = $urandom_range(0, 1) == 1;
            wt = $urandom_range(0, 2) == 0;
            access("RND", we, wt, a, $urandom());
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule